// File: doc/BRIEF.md
# Strap-configured test clock generator

This block sits beside a clock synthesizer and takes care of two jobs that share pins. While power-on reset (`por_n`) is low, four bidirectional pads act as configuration inputs. The block samples them on every rising edge of the reference clock into a 4-bit strap register. When reset is released, the same pads turn into clock outputs. The latched value is then frozen, and later activity on the pads does not change it.

A small mode machine decides what the clock outputs carry. It has three states. `ST_STRAP` is the reset state, in which the outputs are held low and the pad drivers are off. On the first rising edge after reset is released, the machine takes one of two transitions: "strap-to-test" into `ST_TEST` when the frequency-select bits read the production test code, or "strap-to-normal" into `ST_NORMAL` otherwise. Both operating states hold until the next reset.

In test mode the outputs carry fixed divisions of the reference: undivided, divided by 2, divided by 4, and a bus ratio of divide-by-4 or divide-by-3 chosen by a fourth strap. In normal mode every output follows a placeholder clock input. All dividers leave reset together, so every divided clock rises on the same reference edge.

Top module: `tmclk_gen`

## Requirements
- R1: While `por_n` is low, `pad_in` is captured on every rising `ref_clk` edge. After release, the strap register keeps the value from the last such edge, and later changes on `pad_in` have no effect on any output.
- R2: While `por_n` is low, `pad_oe` is 4'b0000 and every clock output (`pad_out`, `ref_out`, `cpu_clk`, `mem_clk`, `bus_clk`) is 0. This takes effect as soon as `por_n` falls, without waiting for a clock edge.
- R3: On the first rising edge with `por_n` high (edge E0), the machine leaves `ST_STRAP`. From then until the next reset, `pad_oe` is 4'b1111.
- R4: Strap bit positions are: bit 0 = frequency select 0, bit 1 = frequency select 1, bit 2 = frequency select 2, bit 3 = bus ratio select. The machine enters `ST_TEST` only when bits [2:0] equal 3'b110; any other code enters `ST_NORMAL`.
- R5: In `ST_TEST`, `ref_out` and `pad_out[0]` equal `ref_clk`.
- R6: In `ST_TEST`, `cpu_clk`, `mem_clk` and `pad_out[1]` are `ref_clk` divided by 2 with 50% duty. They are high for the full cycle that starts at E0.
- R7: In `ST_TEST`, `pad_out[2]` is `ref_clk` divided by 4 with 50% duty. It is high for the two cycles that start at E0.
- R8: In `ST_TEST`, `bus_clk` and `pad_out[3]` carry the bus clock. With strap bit 3 = 1 it matches the divide-by-4 of R7. With bit 3 = 0 it is `ref_clk` divided by 3, high from E0 for 1.5 reference cycles and low for the next 1.5.
- R9: In `ST_NORMAL`, every clock output equals `nrm_clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock; all capture and division is based on it |
| por_n | input | 1 | Active-low power-on reset; straps are sampled while low |
| nrm_clk | input | 1 | Placeholder clock driven out in normal mode |
| pad_in | input | 4 | Input side of the shared strap/clock pads |
| pad_out | output | 4 | Output side of the shared pads: [0] reference, [1] half rate, [2] quarter rate, [3] bus clock |
| pad_oe | output | 4 | Driver enable for the shared pads |
| ref_out | output | 1 | Dedicated reference-rate clock |
| cpu_clk | output | 1 | Processor clock (half rate in test mode) |
| mem_clk | output | 1 | Memory clock (half rate in test mode) |
| bus_clk | output | 1 | Bus clock (quarter or third rate in test mode) |

## Verification
The bench releases reset between two edges after changing the pads just before the final reset edge. A design that latched too early would then read the wrong code and pick the wrong mode. It also drives the inverted strap value onto the pads as soon as reset ends, so a latch that keeps sampling would change the bus ratio or the mode partway through a run. It samples every output in both halves of each reference cycle and counts phase from E0. This catches a divide-by-3 that only uses one edge (a 1/3 duty cycle), dividers whose phase is off by one, and a bus select applied with the wrong polarity. Reset is also asserted in the middle of a cycle, so an output gate that waits for a clock edge would show up as a late, still-running clock. Codes one bit away from the test code must stay in normal mode.

// File: rtl/tmclk_pkg.sv
`timescale 1ns/1ps
package tmclk_pkg;
    localparam int STRAP_W = 4;
    localparam int FSEL0   = 0;
    localparam int FSEL2   = 2;
    localparam int BUS_SEL = 3;
    localparam logic [2:0] TEST_CODE = 3'b110;

    typedef enum logic [1:0] {
        ST_STRAP  = 2'd0,
        ST_TEST   = 2'd1,
        ST_NORMAL = 2'd2
    } mode_e;
endpackage

// File: rtl/tmclk_strap_fsm.sv
`timescale 1ns/1ps
module tmclk_strap_fsm
    import tmclk_pkg::*;
(
    input  logic               ref_clk,
    input  logic               por_n,
    input  logic [STRAP_W-1:0] pad_in,
    output logic [STRAP_W-1:0] strap_q,
    output logic               run,
    output logic               in_test
);
    mode_e mode;
    mode_e mode_nxt;

    // Strap capture: every reference edge while reset is held.
    always_ff @(posedge ref_clk) begin
        if (!por_n) begin
            strap_q <= pad_in;
        end
    end

    // Next-state logic.
    always_comb begin
        mode_nxt = mode;
        unique case (mode)
            ST_STRAP:  mode_nxt = (strap_q[FSEL2:FSEL0] == TEST_CODE) ? ST_TEST : ST_NORMAL;
            ST_TEST:   mode_nxt = ST_TEST;
            ST_NORMAL: mode_nxt = ST_NORMAL;
            default:   mode_nxt = ST_STRAP;
        endcase
    end

    // State register.
    always_ff @(posedge ref_clk or negedge por_n) begin
        if (!por_n) begin
            mode <= ST_STRAP;
        end else begin
            mode <= mode_nxt;
        end
    end

    // State decode.
    always_comb begin
        run     = 1'b0;
        in_test = 1'b0;
        unique case (mode)
            ST_STRAP:  begin run = 1'b0; in_test = 1'b0; end
            ST_TEST:   begin run = 1'b1; in_test = 1'b1; end
            ST_NORMAL: begin run = 1'b1; in_test = 1'b0; end
            default:   begin run = 1'b0; in_test = 1'b0; end
        endcase
    end
endmodule

// File: rtl/tmclk_div_pow2.sv
`timescale 1ns/1ps
module tmclk_div_pow2 #(
    parameter int STAGES = 2
) (
    input  logic              ref_clk,
    input  logic              por_n,
    output logic [STAGES-1:0] q
);
    logic [STAGES-1:0] tgl;

    // Ripple-free toggle chain: stage i flips when all lower stages are low.
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic bit_q;
        if (i == 0) begin : g_first
            assign tgl[i] = 1'b1;
        end else begin : g_next
            assign tgl[i] = tgl[i-1] & ~q[i-1];
        end

        always_ff @(posedge ref_clk or negedge por_n) begin
            if (!por_n) begin
                bit_q <= 1'b0;
            end else if (tgl[i]) begin
                bit_q <= ~bit_q;
            end
        end
        assign q[i] = bit_q;
    end
endmodule

// File: rtl/tmclk_div_odd.sv
`timescale 1ns/1ps
module tmclk_div_odd #(
    parameter int ODD_DIV = 3
) (
    input  logic ref_clk,
    input  logic por_n,
    output logic clk_o,
    output logic rise_ph
);
    localparam int CW = (ODD_DIV > 2) ? $clog2(ODD_DIV) : 1;
    localparam logic [CW-1:0] LAST  = CW'(ODD_DIV - 1);
    localparam logic [CW-1:0] HIGHN = CW'((ODD_DIV - 1) / 2);

    logic [CW-1:0] cnt;
    logic          fall_ph;

    always_ff @(posedge ref_clk or negedge por_n) begin
        if (!por_n) begin
            cnt     <= '0;
            rise_ph <= 1'b0;
        end else begin
            rise_ph <= (cnt < HIGHN);
            cnt     <= (cnt == LAST) ? '0 : cnt + CW'(1);
        end
    end

    // Half-cycle extension on the falling edge gives 50% duty.
    always_ff @(negedge ref_clk or negedge por_n) begin
        if (!por_n) begin
            fall_ph <= 1'b0;
        end else begin
            fall_ph <= rise_ph;
        end
    end

    assign clk_o = rise_ph | fall_ph;
endmodule

// File: rtl/tmclk_gen.sv
`timescale 1ns/1ps
module tmclk_gen
    import tmclk_pkg::*;
(
    input  logic               ref_clk,
    input  logic               por_n,
    input  logic               nrm_clk,
    input  logic [STRAP_W-1:0] pad_in,
    output logic [STRAP_W-1:0] pad_out,
    output logic [STRAP_W-1:0] pad_oe,
    output logic               ref_out,
    output logic               cpu_clk,
    output logic               mem_clk,
    output logic               bus_clk
);
    localparam int POW2_STAGES = 2;
    localparam int BUS_ODD_DIV = 3;

    logic [STRAP_W-1:0]     strap_q;
    logic                   run;
    logic                   in_test;
    logic [POW2_STAGES-1:0] pw;
    logic                   d3_clk;
    logic                   div3_rise;
    logic                   t_bus;

    tmclk_strap_fsm u_fsm (
        .ref_clk (ref_clk),
        .por_n   (por_n),
        .pad_in  (pad_in),
        .strap_q (strap_q),
        .run     (run),
        .in_test (in_test)
    );

    tmclk_div_pow2 #(.STAGES(POW2_STAGES)) u_pow2 (
        .ref_clk (ref_clk),
        .por_n   (por_n),
        .q       (pw)
    );

    tmclk_div_odd #(.ODD_DIV(BUS_ODD_DIV)) u_odd (
        .ref_clk (ref_clk),
        .por_n   (por_n),
        .clk_o   (d3_clk),
        .rise_ph (div3_rise)
    );

    assign t_bus = strap_q[BUS_SEL] ? pw[POW2_STAGES-1] : d3_clk;

    always_comb begin
        pad_oe = {STRAP_W{run}};
        if (!run) begin
            pad_out = '0;
            ref_out = 1'b0;
            cpu_clk = 1'b0;
            mem_clk = 1'b0;
            bus_clk = 1'b0;
        end else if (!in_test) begin
            pad_out = {STRAP_W{nrm_clk}};
            ref_out = nrm_clk;
            cpu_clk = nrm_clk;
            mem_clk = nrm_clk;
            bus_clk = nrm_clk;
        end else begin
            pad_out = {t_bus, pw[1], pw[0], ref_clk};
            ref_out = ref_clk;
            cpu_clk = pw[0];
            mem_clk = pw[0];
            bus_clk = t_bus;
        end
    end
endmodule

// File: rtl/tmclk_gen_chk.sv
`timescale 1ns/1ps
module tmclk_gen_chk (
    input logic       ref_clk,
    input logic       por_n,
    input logic [3:0] pad_oe,
    input logic [3:0] pad_out,
    input logic       ref_out,
    input logic       cpu_clk,
    input logic       mem_clk,
    input logic       bus_clk,
    input logic       in_test,
    input logic [3:0] strap_q,
    input logic       div3_rise
);
    a_r2_quiet_in_reset: assert property (@(negedge ref_clk)
        !por_n |-> (pad_oe == 4'b0000 && pad_out == 4'b0000 &&
                    !ref_out && !cpu_clk && !mem_clk && !bus_clk));

    a_r3_oe_stays_on: assert property (@(posedge ref_clk) disable iff (!por_n)
        (pad_oe != 4'b0000) |=> (pad_oe == 4'b1111));

    a_r1_strap_frozen: assert property (@(posedge ref_clk) disable iff (!por_n)
        $past(por_n) |-> $stable(strap_q));

    a_r6_half_rate_toggles: assert property (@(posedge ref_clk) disable iff (!por_n)
        (in_test && $past(in_test)) |-> (cpu_clk != $past(cpu_clk)));

    a_r8_third_rate_pulse: assert property (@(posedge ref_clk) disable iff (!por_n)
        (in_test && $past(in_test) && $past(in_test, 2) && !strap_q[3])
        |-> ($countones({div3_rise, $past(div3_rise), $past(div3_rise, 2)}) == 1));
endmodule

bind tmclk_gen tmclk_gen_chk u_chk (
    .ref_clk   (ref_clk),
    .por_n     (por_n),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .ref_out   (ref_out),
    .cpu_clk   (cpu_clk),
    .mem_clk   (mem_clk),
    .bus_clk   (bus_clk),
    .in_test   (in_test),
    .strap_q   (strap_q),
    .div3_rise (div3_rise)
);

// File: tb/tmclk_gen_bench.sv
`timescale 1ns/1ps
module tmclk_gen_bench;
    logic       ref_clk = 1'b0;
    logic       por_n   = 1'b0;
    logic       nrm_clk = 1'b0;
    logic [3:0] pad_in  = 4'b0000;
    logic [3:0] pad_out;
    logic [3:0] pad_oe;
    logic       ref_out;
    logic       cpu_clk;
    logic       mem_clk;
    logic       bus_clk;

    int checks = 0;
    int errors = 0;

    always #2.5 ref_clk = ~ref_clk;
    always #3.5 nrm_clk = ~nrm_clk;

    tmclk_gen u_tmclk_gen (
        .ref_clk (ref_clk),
        .por_n   (por_n),
        .nrm_clk (nrm_clk),
        .pad_in  (pad_in),
        .pad_out (pad_out),
        .pad_oe  (pad_oe),
        .ref_out (ref_out),
        .cpu_clk (cpu_clk),
        .mem_clk (mem_clk),
        .bus_clk (bus_clk)
    );

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t actual=%b expected=%b", tag, $time, act, exp);
        end
    endtask

    task automatic chk_quiet(input string tag);
        chk({tag, " pad_oe"}, pad_oe, 4'b0000);
        chk({tag, " pad_out"}, pad_out, 4'b0000);
        chk({tag, " dedicated"}, {ref_out, cpu_clk, mem_clk, bus_clk}, 4'b0000);
    endtask

    // Reference model: k = reference cycles since E0, half = 0 in the high phase.
    task automatic chk_test(input int k, input bit half, input bit bsel, input bit after_pads);
        logic r, d2, d4, d3, bus;
        r   = !half;
        d2  = (k % 2) == 0;
        d4  = (k % 4) < 2;
        d3  = half ? ((k % 3) == 0) : ((k % 3) != 2);
        bus = bsel ? d4 : d3;
        chk("R3 pad_oe on", pad_oe, 4'b1111);
        chk("R5 reference rate", {2'b00, ref_out, pad_out[0]}, {2'b00, r, r});
        chk("R6 half rate", {1'b0, cpu_clk, mem_clk, pad_out[1]}, {1'b0, d2, d2, d2});
        chk("R7 quarter rate", {3'b000, pad_out[2]}, {3'b000, d4});
        chk(after_pads ? "R1 strap frozen, bus" : "R8 bus ratio",
            {2'b00, bus_clk, pad_out[3]}, {2'b00, bus, bus});
    endtask

    task automatic enter_reset(input logic [3:0] s);
        por_n  = 1'b0;
        pad_in = ~s;
        #0.5;
        chk_quiet("R2 immediate");
        repeat (3) begin
            @(posedge ref_clk); #1.25; chk_quiet("R2 high phase");
            @(negedge ref_clk); #1.25; chk_quiet("R2 low phase");
        end
        @(negedge ref_clk);
        pad_in = s;
        @(posedge ref_clk);
        @(negedge ref_clk);
        #1;
        por_n  = 1'b1;
        pad_in = ~s;
    endtask

    task automatic run_test(input logic [3:0] s, input int n);
        enter_reset(s);
        for (int k = 0; k < n; k++) begin
            @(posedge ref_clk); #1.25; chk_test(k, 1'b0, s[3], k >= 4);
            @(negedge ref_clk); #1.25; chk_test(k, 1'b1, s[3], k >= 4);
        end
    endtask

    task automatic run_normal(input logic [3:0] s, input int n);
        enter_reset(s);
        for (int k = 0; k < 2 * n; k++) begin
            if (k % 2 == 0) @(posedge ref_clk); else @(negedge ref_clk);
            #1.25;
            chk("R3 pad_oe on", pad_oe, 4'b1111);
            chk("R4 R9 normal pads", pad_out, {4{nrm_clk}});
            chk("R4 R9 normal dedicated", {ref_out, cpu_clk, mem_clk, bus_clk}, {4{nrm_clk}});
        end
    endtask

    initial begin : watchdog
        #200000;
        errors++;
        $display("FAIL watchdog R3 actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        run_test(4'b0110, 24);   // test mode, bus = ref/3
        run_test(4'b1110, 24);   // test mode, bus = ref/4
        run_normal(4'b0111, 10); // FS0 set: normal
        run_normal(4'b1010, 10); // FS2 clear: normal
        run_normal(4'b0100, 8);  // FS1 clear: normal
        run_test(4'b0110, 12);   // re-entry after normal mode
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule